// File: doc/BRIEF.md
# Serial-Loaded Trim Code Register Bank

This block is the digital core of a twenty-output trim converter. A host writes settings over a slow three-wire serial port made of a shift clock, a data line and a load strobe. Each 16-bit command is shifted in least significant bit first. It carries an 8-bit code in its upper byte and a 5-bit register address in its lowest bits. When the load strobe rises, the code is written into one of 24 holding registers. The analog ladders downstream turn each presented code into a voltage. Code 00h is the lowest level and code FFh is 255/256 of full scale.

Sixteen of the outputs each show their own register. The remaining four outputs are each backed by two registers, called set 0 and set 1. A select pin chooses which of the two sets all four of these outputs present. The host can therefore preload two complete configurations and switch between them with a single pin.

All four serial pins are asynchronous to the system clock. They are resynchronized and edge-detected in the system clock domain, so the system clock must run at least eight times faster than the serial clock.

Top module: `trim_bank_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, every output code is 00h and `wr_stb_o` is low.
- R2: Data bits are taken on rising edges of `ser_clk_i`, least significant bit first. After 16 bits, frame bits [15:8] are the code and bits [4:0] are the address. Bits [7:5] have no effect on which register is written or on the value written.
- R3: Addresses 1 to 16 write the register shown on output `code_o[addr-1]`.
- R4: Addresses 17 to 20 write set 0 of extension outputs 16 to 19. Addresses 21 to 24 write set 1 of the same outputs.
- R5: Address 0 and addresses 25 to 31 write no register and raise no strobe.
- R6: A write takes place once, on each rising edge of `ser_load_i`. It uses the last 16 bits shifted in. If fewer than 16 bits arrived since the previous load, nothing is written.
- R7: Between accepted writes and select changes, every output holds its value.
- R8: When `ext_sel_i` is low, outputs 16 to 19 present their set 0 registers. When it is high, they present their set 1 registers.
- R9: Each accepted write produces a strobe exactly one cycle long on `wr_stb_o`. `wr_idx_o` equals the address minus 1 during that cycle.
- R10: The bit count clears on each load. A second load with no new bits writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Active-high reset, asynchronous assert |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_load_i | input | 1 | Load strobe; its rising edge commits a frame |
| ext_sel_i | input | 1 | Chooses set 0 (low) or set 1 (high) for the four extension outputs |
| code_o | output | 160 | Twenty 8-bit codes packed, output n in bits [8n+7:8n] |
| wr_stb_o | output | 1 | One-cycle pulse for each accepted write |
| wr_idx_o | output | 5 | Register index (address minus 1) written, valid with the strobe |

## Verification
A load reaches the outputs four system-clock edges after the pin rises: two synchronizer stages, one edge-detect and capture stage, and one register write. The strobe appears on that same edge. A select change reaches the outputs two edges after the pin moves. The bench drives every pin on falling clock edges. After each load it holds the strobe low and waits eleven cycles before comparing outputs. After each select change it waits five cycles. This keeps every comparison clear of the moment a result is due. Strobes are counted by a monitor over the whole load window, so a missing strobe, an extra strobe or a wrong index is caught regardless of the exact cycle it fell in.

// File: rtl/trim_bank_pkg.sv
package trim_bank_pkg;
   // Class of register an address selects
   typedef enum logic [1:0] {
      SLOT_NONE   = 2'd0,
      SLOT_DIRECT = 2'd1,
      SLOT_SET0   = 2'd2,
      SLOT_SET1   = 2'd3
   } slot_kind_e;
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("trim_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/trim_shifter.sv
module trim_shifter #(
   parameter int FRAME_W = 16,
   parameter int CODE_W  = 8,
   parameter int ADDR_W  = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sclk_i,
   input  logic              sdat_i,
   input  logic              load_i,
   output logic              commit_o,
   output logic [CODE_W-1:0] code_o,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int CNT_W = $clog2(FRAME_W + 1);

   generate
      if (FRAME_W < CODE_W + ADDR_W) begin : g_bad
         $error("trim_shifter: frame too narrow for code and address");
      end
   endgenerate

   logic [FRAME_W-1:0] sreg;
   logic [CNT_W-1:0]   bit_cnt;
   logic               sclk_q, load_q;
   logic               sclk_rise, load_rise;

   assign sclk_rise = sclk_i & ~sclk_q;
   assign load_rise = load_i & ~load_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         sclk_q   <= 1'b0;
         load_q   <= 1'b0;
         sreg     <= '0;
         bit_cnt  <= '0;
         commit_o <= 1'b0;
         code_o   <= '0;
         addr_o   <= '0;
      end else begin
         sclk_q   <= sclk_i;
         load_q   <= load_i;
         commit_o <= 1'b0;
         if (load_rise) begin
            commit_o <= (bit_cnt == CNT_W'(FRAME_W));
            code_o   <= sreg[FRAME_W-1 -: CODE_W];
            addr_o   <= sreg[ADDR_W-1:0];
            sreg     <= '0;
            bit_cnt  <= '0;
         end else if (sclk_rise) begin
            sreg <= {sdat_i, sreg[FRAME_W-1:1]};
            if (bit_cnt != CNT_W'(FRAME_W)) bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   // R6: the saturating bit count never passes the frame length
   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
      bit_cnt <= CNT_W'(FRAME_W));

   // R10: a commit is never produced two cycles running
   assert_commit_once_R10: assert property (@(posedge clk) disable iff (rst)
      commit_o |=> !commit_o);
endmodule

// File: rtl/trim_decode.sv
module trim_decode
   import trim_bank_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int N_DIRECT = 16,
   parameter int N_EXT    = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic [ADDR_W-1:0] idx_o,
   output slot_kind_e        kind_o
);
   localparam int N_REG = N_DIRECT + 2 * N_EXT;

   generate
      if (N_REG >= (1 << ADDR_W)) begin : g_bad
         $error("trim_decode: address field cannot reach all registers");
      end
   endgenerate

   always_comb begin
      if (addr_i == '0)                                kind_o = SLOT_NONE;
      else if (addr_i <= ADDR_W'(N_DIRECT))            kind_o = SLOT_DIRECT;
      else if (addr_i <= ADDR_W'(N_DIRECT + N_EXT))    kind_o = SLOT_SET0;
      else if (addr_i <= ADDR_W'(N_REG))               kind_o = SLOT_SET1;
      else                                             kind_o = SLOT_NONE;
   end

   assign hit_o = (kind_o != SLOT_NONE);
   assign idx_o = addr_i - 1'b1;
endmodule

// File: rtl/trim_regbank.sv
module trim_regbank #(
   parameter int CODE_W   = 8,
   parameter int IDX_W    = 5,
   parameter int N_DIRECT = 16,
   parameter int N_EXT    = 4,
   localparam int N_REG   = N_DIRECT + 2 * N_EXT,
   localparam int N_OUT   = N_DIRECT + N_EXT
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         we_i,
   input  logic [IDX_W-1:0]             idx_i,
   input  logic [CODE_W-1:0]            code_i,
   input  logic                         sel_i,
   output logic [N_OUT-1:0][CODE_W-1:0] out_o
);
   logic [N_REG-1:0][CODE_W-1:0] regs;

   generate
      for (genvar r = 0; r < N_REG; r++) begin : g_reg
         always_ff @(posedge clk or posedge rst) begin
            if (rst)                               regs[r] <= '0;
            else if (we_i && idx_i == IDX_W'(r))   regs[r] <= code_i;
         end
      end
      for (genvar o = 0; o < N_DIRECT; o++) begin : g_direct
         assign out_o[o] = regs[o];
      end
      for (genvar e = 0; e < N_EXT; e++) begin : g_ext
         assign out_o[N_DIRECT+e] = sel_i ? regs[N_DIRECT+N_EXT+e] : regs[N_DIRECT+e];
      end
   endgenerate

   // R5: a write never targets an index outside the bank
   assert_we_in_range_R5: assert property (@(posedge clk) disable iff (rst)
      we_i |-> (idx_i < IDX_W'(N_REG)));
endmodule

// File: rtl/trim_bank_top.sv
module trim_bank_top
   import trim_bank_pkg::*;
#(
   parameter int CODE_W      = 8,
   parameter int ADDR_W      = 5,
   parameter int FRAME_W     = 16,
   parameter int N_DIRECT    = 16,
   parameter int N_EXT       = 4,
   parameter int SYNC_STAGES = 2,
   localparam int N_OUT      = N_DIRECT + N_EXT
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         ser_clk_i,
   input  logic                         ser_dat_i,
   input  logic                         ser_load_i,
   input  logic                         ext_sel_i,
   output logic [N_OUT-1:0][CODE_W-1:0] code_o,
   output logic                         wr_stb_o,
   output logic [ADDR_W-1:0]            wr_idx_o
);
   logic [3:0]        pins_s;
   logic              commit;
   logic [CODE_W-1:0] f_code;
   logic [ADDR_W-1:0] f_addr, d_idx;
   logic              d_hit, we;
   slot_kind_e        d_kind;

   trim_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst (rst),
      .d_i ({ext_sel_i, ser_load_i, ser_dat_i, ser_clk_i}),
      .q_o (pins_s)
   );

   trim_shifter #(.FRAME_W(FRAME_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_shift (
      .clk (clk), .rst (rst),
      .sclk_i (pins_s[0]), .sdat_i (pins_s[1]), .load_i (pins_s[2]),
      .commit_o (commit), .code_o (f_code), .addr_o (f_addr)
   );

   trim_decode #(.ADDR_W(ADDR_W), .N_DIRECT(N_DIRECT), .N_EXT(N_EXT)) u_dec (
      .addr_i (f_addr), .hit_o (d_hit), .idx_o (d_idx), .kind_o (d_kind)
   );

   assign we = commit & d_hit;

   trim_regbank #(.CODE_W(CODE_W), .IDX_W(ADDR_W), .N_DIRECT(N_DIRECT), .N_EXT(N_EXT)) u_bank (
      .clk (clk), .rst (rst), .we_i (we), .idx_i (d_idx), .code_i (f_code),
      .sel_i (pins_s[3]), .out_o (code_o)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         wr_stb_o <= 1'b0;
         wr_idx_o <= '0;
      end else begin
         wr_stb_o <= we;
         wr_idx_o <= d_idx;
      end
   end

   // R9: the strobe lasts exactly one cycle
   assert_stb_single_R9: assert property (@(posedge clk) disable iff (rst)
      wr_stb_o |=> !wr_stb_o);

   // R7: outputs move only with a write or a select change
   assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (!wr_stb_o && $stable(pins_s[3])) |-> $stable(code_o));

   // R5: a reported write names a real register
   assert_idx_range_R5: assert property (@(posedge clk) disable iff (rst)
      wr_stb_o |-> (wr_idx_o < ADDR_W'(N_DIRECT + 2 * N_EXT)));

   // R4: a write raised for an extension slot is flagged by the decoder
   assert_ext_kind_R4: assert property (@(posedge clk) disable iff (rst)
      (we && d_idx >= ADDR_W'(N_DIRECT)) |-> (d_kind == SLOT_SET0 || d_kind == SLOT_SET1));
endmodule

// File: tb/trim_bank_top_bench.sv
`timescale 1ns/1ps
module trim_bank_top_bench;
   localparam int NO = 20;
   localparam int NR = 24;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sck = 1'b0, sdi = 1'b0, sld = 1'b0, ssel = 1'b0;
   logic [NO-1:0][7:0] codes;
   logic       stb;
   logic [4:0] idx;

   always #5 clk = ~clk;

   trim_bank_top u_trim_bank_top (
      .clk (clk), .rst (rst), .ser_clk_i (sck), .ser_dat_i (sdi),
      .ser_load_i (sld), .ext_sel_i (ssel), .code_o (codes),
      .wr_stb_o (stb), .wr_idx_o (idx)
   );

   int n_run = 0, n_fail = 0;
   int stb_cnt = 0;
   logic [4:0] stb_idx = '0;
   logic [7:0] mreg [NR];
   logic       msel = 1'b0;
   bit         done = 1'b0;

   always @(posedge clk) if (!rst && stb) begin
      stb_cnt <= stb_cnt + 1;
      stb_idx <= idx;
   end

   function automatic logic [7:0] exp_out(int o);
      if (o < 16) return mreg[o];
      return msel ? mreg[20 + o - 16] : mreg[16 + o - 16];
   endfunction

   function automatic bit addr_valid(int a);
      return (a >= 1) && (a <= NR);
   endfunction

   task automatic check_outs(string req);
      int bad = -1;
      n_run++;
      for (int o = 0; o < NO; o++) if (codes[o] !== exp_out(o) && bad < 0) bad = o;
      if (bad >= 0) begin
         n_fail++;
         $display("FAIL %s: output %0d actual %h expected %h", req, bad, codes[bad], exp_out(bad));
      end
   endtask

   task automatic check_stb(int base, int exp_n, int exp_idx, string req);
      n_run++;
      if (stb_cnt - base != exp_n || (exp_n > 0 && stb_idx != 5'(exp_idx))) begin
         n_fail++;
         $display("FAIL %s: strobes %0d idx %0d, expected %0d idx %0d",
                  req, stb_cnt - base, stb_idx, exp_n, exp_idx);
      end
   endtask

   task automatic shift_bits(logic [31:0] v, int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); sdi = v[i];
         repeat (3) @(negedge clk); sck = 1'b1;
         repeat (4) @(negedge clk); sck = 1'b0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic pulse_load();
      @(negedge clk); sld = 1'b1;
      repeat (5) @(negedge clk); sld = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic send(logic [7:0] code, int addr, logic [2:0] junk, string req);
      int base = stb_cnt;
      shift_bits({16'h0, code, junk, 5'(addr)}, 16);
      pulse_load();
      if (addr_valid(addr)) begin
         mreg[addr-1] = code;
         check_stb(base, 1, addr - 1, req);
      end else begin
         check_stb(base, 0, 0, req);
      end
      check_outs(req);
   endtask

   task automatic set_sel(logic v, string req);
      @(negedge clk); ssel = v;
      repeat (5) @(negedge clk);
      msel = v;
      check_outs(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int base;
      void'($urandom(32'd2718));
      for (int r = 0; r < NR; r++) mreg[r] = 8'h00;
      repeat (4) @(negedge clk);
      check_outs("R1 in reset");
      rst = 1'b0;
      @(negedge clk);
      n_run++;
      if (stb !== 1'b0) begin n_fail++; $display("FAIL R1: strobe %b expected 0", stb); end
      check_outs("R1 after reset");

      // direct and extension slots, with junk in bits 7:5
      send(8'hA5, 1, 3'b000, "R3 first direct");
      send(8'hFF, 16, 3'b111, "R2 R3 last direct, bits 7:5 set");
      send(8'h3C, 17, 3'b101, "R4 first set0");
      send(8'hC3, 21, 3'b010, "R4 first set1");
      send(8'h11, 24, 3'b000, "R4 last set1");
      set_sel(1'b1, "R8 sel high shows set1");
      set_sel(1'b0, "R8 sel low shows set0");

      // reserved addresses
      send(8'h77, 0, 3'b000, "R5 address 0");
      send(8'h88, 25, 3'b000, "R5 address 25");
      send(8'h99, 31, 3'b111, "R5 address 31");

      // short frame then load: nothing written
      base = stb_cnt;
      shift_bits({16'h0, 8'h5A, 3'b000, 5'd2}, 10);
      pulse_load();
      check_stb(base, 0, 0, "R6 short frame");
      check_outs("R6 short frame");

      // load without data after a good load
      send(8'h42, 3, 3'b000, "R6 good load");
      base = stb_cnt;
      pulse_load();
      check_stb(base, 0, 0, "R10 bare load");
      check_outs("R10 bare load");

      // over-long frame: last 16 bits count
      base = stb_cnt;
      shift_bits({12'h0, 8'hE7, 3'b000, 5'd5, 4'b1011}, 20);
      pulse_load();
      mreg[4] = 8'hE7;
      check_stb(base, 1, 4, "R6 long frame keeps last 16");
      check_outs("R6 long frame");

      // hold with no activity
      repeat (40) @(negedge clk);
      check_outs("R7 idle hold");

      // random traffic
      for (int k = 0; k < 120; k++) begin
         logic [7:0] c = 8'($urandom);
         int a = int'($urandom_range(31, 0));
         logic [2:0] j = 3'($urandom);
         send(c, a, j, "R2 R3 R4 R5 random frame");
         if ($urandom_range(7, 0) == 0) set_sel(~msel, "R8 random select");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule